// File: doc/BRIEF.md
# Instruction Reuse Buffer

This block is a direct-mapped table of results from committed instructions. A pipeline looks up an instruction by its PC. If an earlier, committed instance of the same instruction saw the same source operand values, the pipeline can take the stored result and skip execution. For loads, the table also returns the computed memory address. It reports whether the value loaded earlier can still be used, or whether a later store may have changed that memory location.

A lookup takes two steps. In the request cycle the PC is presented and the tag comparison is done. In the next cycle the two operand values are presented and compared against the stored ones. The answer is registered and appears one cycle after the operands. A commit port fills the table with committed, non-speculative results. A store port broadcasts every store address to all entries at once and withdraws the load-value permission from every entry that recorded that address.

None of the three ports has back-pressure. Every port accepts one transfer in each cycle in which its valid input is high, and the result stream cannot be stalled. The operand values for a request must arrive in exactly the cycle after the PC, and the source must not hold them back. The PC index is taken from `pc[ALIGN +: log2(ENTRIES)]`. All remaining PC bits form the tag. `ENTRIES` must be a power of two and `ALIGN` must be at least 1.

Top module: `reuse_buffer`

## Requirements
- R1: After reset every entry is empty, `rs_valid` is low, and any lookup misses until a commit fills the entry it needs.
- R2: A request with `lk_valid` high in cycle t produces `rs_valid` high in cycle t+2. `rs_valid` is low in cycle t+2 if no request was made in cycle t. The operand values for that request are sampled in cycle t+1.
- R3: A lookup hits only when all of these hold: the indexed entry is filled, its stored tag equals the tag of the request PC, the first operand equals the stored first operand, and the second operand equals the stored second operand.
- R4: An entry committed with `cm_single` high ignores the second operand when it is compared, so any second operand value can hit.
- R5: Two PCs with the same index bits and different tags share one slot. A commit of one PC replaces the other, and a lookup of the replaced PC then misses.
- R6: A commit replaces the whole entry at its index. A commit with `cm_load` high sets the load-value flag to 1. A commit with `cm_load` low sets the load-value flag to 0.
- R7: On a hit the block returns the stored result and the stored address. `rs_mem_ok` equals hit AND the entry holds a load AND the entry's load-value flag is set.
- R8: A store clears the load-value flag, in the same cycle, of every entry whose stored address equals `st_addr`. Entries with other addresses keep their flag.
- R9: If a commit and a store hit the same entry in the same cycle and the committed address equals the store address, the entry's load-value flag ends at 0.
- R10: A request that sees a commit to its own index in the request cycle misses. A commit in the operand cycle has no effect on that request, which is answered from the entry as it stood before that commit.
- R11: When `rs_valid` is high and `rs_hit` is low, `rs_result`, `rs_addr` and `rs_mem_ok` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request in this cycle |
| lk_pc | input | PC_W | PC of the lookup request |
| lk_opa | input | DATA_W | First operand of the request made in the previous cycle |
| lk_opb | input | DATA_W | Second operand of the request made in the previous cycle |
| rs_valid | output | 1 | A lookup answer is present |
| rs_hit | output | 1 | The instruction can be reused |
| rs_mem_ok | output | 1 | The stored loaded value can also be reused |
| rs_result | output | DATA_W | Stored result on a hit, 0 otherwise |
| rs_addr | output | ADDR_W | Stored memory address on a hit, 0 otherwise |
| cm_valid | input | 1 | Commit write in this cycle |
| cm_pc | input | PC_W | PC of the committing instruction |
| cm_single | input | 1 | Instruction has one source operand |
| cm_load | input | 1 | Instruction is a load |
| cm_opa | input | DATA_W | Committed first operand value |
| cm_opb | input | DATA_W | Committed second operand value |
| cm_result | input | DATA_W | Committed result value |
| cm_addr | input | ADDR_W | Committed memory address |
| st_valid | input | 1 | Store broadcast in this cycle |
| st_addr | input | ADDR_W | Address written by the store |

## Verification
The assertions assume a single source of requests, with one answer produced for each request cycle. They also assume reset is asserted at time zero, so the pipeline flags start at a known value. They make no assumption about data values. The random stimulus draws PCs, operand values and addresses from small pools. This keeps the inputs valid while making index collisions, operand matches, same-cycle commits and store hits frequent. The operand values for a request are always driven in the single cycle after its PC, as the port rules require.

// File: rtl/irb_pkg.sv
package irb_pkg;

  // Per-entry control bits kept beside the data fields.
  typedef struct packed {
    logic single;    // second operand ignored in comparison
    logic is_load;   // entry holds a load
    logic memvalid;  // loaded value still usable
  } irb_flags_t;

endpackage

// File: rtl/irb_pc_split.sv
module irb_pc_split #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int ALIGN = 2
) (
  input  logic [PC_W-1:0]       pc,
  output logic [IDX_W-1:0]      idx,
  output logic [PC_W-IDX_W-1:0] tag
);
  // Index from the bits above the alignment field; every other bit is tag.
  assign idx = pc[ALIGN +: IDX_W];
  assign tag = {pc[PC_W-1:ALIGN+IDX_W], pc[ALIGN-1:0]};
endmodule

// File: rtl/irb_table.sv
module irb_table
  import irb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 28,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_single,
  input  logic              wr_load,
  input  logic [DATA_W-1:0] wr_opa,
  input  logic [DATA_W-1:0] wr_opb,
  input  logic [DATA_W-1:0] wr_res,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              inv_en,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic [ENTRIES-1:0] ent_valid,
  output irb_flags_t        ent_flags [ENTRIES],
  output logic [TAG_W-1:0]  ent_tag   [ENTRIES],
  output logic [DATA_W-1:0] ent_opa   [ENTRIES],
  output logic [DATA_W-1:0] ent_opb   [ENTRIES],
  output logic [DATA_W-1:0] ent_res   [ENTRIES],
  output logic [ADDR_W-1:0] ent_addr  [ENTRIES]
);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              sel;
    logic              kill;
    logic              mv_nxt;
    logic [ADDR_W-1:0] addr_nxt;
    logic              v_q;
    irb_flags_t        f_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] opa_q, opb_q, res_q;
    logic [ADDR_W-1:0] addr_q;

    assign sel      = wr_en && (wr_idx == IDX_W'(e));
    // Store snoop compares the address the entry will hold after this edge,
    // so a same-cycle commit and matching store leave memvalid clear.
    assign addr_nxt = sel ? wr_addr : addr_q;
    assign mv_nxt   = sel ? wr_load : f_q.memvalid;
    assign kill     = inv_en && (addr_nxt == inv_addr);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        f_q <= '0;
      end else begin
        if (sel) begin
          v_q       <= 1'b1;
          f_q.single  <= wr_single;
          f_q.is_load <= wr_load;
        end
        f_q.memvalid <= mv_nxt & ~kill;
      end
    end

    // Datapath fields need no reset: the valid bit guards them.
    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q  <= wr_tag;
        opa_q  <= wr_opa;
        opb_q  <= wr_opb;
        res_q  <= wr_res;
        addr_q <= wr_addr;
      end
    end

    assign ent_valid[e] = v_q;
    assign ent_flags[e] = f_q;
    assign ent_tag[e]   = tag_q;
    assign ent_opa[e]   = opa_q;
    assign ent_opb[e]   = opb_q;
    assign ent_res[e]   = res_q;
    assign ent_addr[e]  = addr_q;
  end

endmodule

// File: rtl/irb_tag_stage.sv
module irb_tag_stage #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [IDX_W-1:0]   lk_idx,
  input  logic [TAG_W-1:0]   lk_tag,
  input  logic               cm_valid,
  input  logic [IDX_W-1:0]   cm_idx,
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [TAG_W-1:0]   ent_tag [ENTRIES],
  output logic               s1_valid,
  output logic [IDX_W-1:0]   s1_idx,
  output logic               s1_taghit
);

  logic tag_eq;
  logic overwritten;

  assign tag_eq      = ent_valid[lk_idx] && (ent_tag[lk_idx] == lk_tag);
  // An entry being replaced this cycle would reach the operand stage with
  // contents different from the ones whose tag was checked: force a miss.
  assign overwritten = cm_valid && (cm_idx == lk_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_taghit <= 1'b0;
      s1_idx    <= '0;
    end else begin
      s1_valid  <= lk_valid;
      s1_taghit <= lk_valid && tag_eq && !overwritten;
      s1_idx    <= lk_idx;
    end
  end

endmodule

// File: rtl/irb_opnd_stage.sv
module irb_opnd_stage
  import irb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  logic [IDX_W-1:0]  s1_idx,
  input  logic              s1_taghit,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  irb_flags_t        ent_flags [ENTRIES],
  input  logic [DATA_W-1:0] ent_opa   [ENTRIES],
  input  logic [DATA_W-1:0] ent_opb   [ENTRIES],
  input  logic [DATA_W-1:0] ent_res   [ENTRIES],
  input  logic [ADDR_W-1:0] ent_addr  [ENTRIES],
  output logic              rs_valid,
  output logic              rs_hit,
  output logic              rs_mem_ok,
  output logic [DATA_W-1:0] rs_result,
  output logic [ADDR_W-1:0] rs_addr
);

  irb_flags_t sel_f;
  logic       a_eq, b_eq, hit;

  assign sel_f = ent_flags[s1_idx];
  assign a_eq  = (opa == ent_opa[s1_idx]);
  assign b_eq  = sel_f.single || (opb == ent_opb[s1_idx]);
  assign hit   = s1_valid && s1_taghit && a_eq && b_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid  <= 1'b0;
      rs_hit    <= 1'b0;
      rs_mem_ok <= 1'b0;
      rs_result <= '0;
      rs_addr   <= '0;
    end else begin
      rs_valid  <= s1_valid;
      rs_hit    <= hit;
      rs_mem_ok <= hit && sel_f.is_load && sel_f.memvalid;
      rs_result <= hit ? ent_res[s1_idx]  : '0;
      rs_addr   <= hit ? ent_addr[s1_idx] : '0;
    end
  end

endmodule

// File: rtl/reuse_buffer.sv
module reuse_buffer
  import irb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 16,
  parameter int ALIGN   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [DATA_W-1:0] lk_opa,
  input  logic [DATA_W-1:0] lk_opb,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic              rs_mem_ok,
  output logic [DATA_W-1:0] rs_result,
  output logic [ADDR_W-1:0] rs_addr,
  input  logic              cm_valid,
  input  logic [PC_W-1:0]   cm_pc,
  input  logic              cm_single,
  input  logic              cm_load,
  input  logic [DATA_W-1:0] cm_opa,
  input  logic [DATA_W-1:0] cm_opb,
  input  logic [DATA_W-1:0] cm_result,
  input  logic [ADDR_W-1:0] cm_addr,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W;

  logic [IDX_W-1:0]   lk_idx, cm_idx;
  logic [TAG_W-1:0]   lk_tag, cm_tag;
  logic [ENTRIES-1:0] ent_valid;
  irb_flags_t         ent_flags [ENTRIES];
  logic [TAG_W-1:0]   ent_tag   [ENTRIES];
  logic [DATA_W-1:0]  ent_opa   [ENTRIES];
  logic [DATA_W-1:0]  ent_opb   [ENTRIES];
  logic [DATA_W-1:0]  ent_res   [ENTRIES];
  logic [ADDR_W-1:0]  ent_addr  [ENTRIES];
  logic               s1_valid, s1_taghit;
  logic [IDX_W-1:0]   s1_idx;

  irb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_split_lk (
    .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
  );

  irb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_split_cm (
    .pc(cm_pc), .idx(cm_idx), .tag(cm_tag)
  );

  irb_table #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cm_valid),
    .wr_idx    (cm_idx),
    .wr_tag    (cm_tag),
    .wr_single (cm_single),
    .wr_load   (cm_load),
    .wr_opa    (cm_opa),
    .wr_opb    (cm_opb),
    .wr_res    (cm_result),
    .wr_addr   (cm_addr),
    .inv_en    (st_valid),
    .inv_addr  (st_addr),
    .ent_valid (ent_valid),
    .ent_flags (ent_flags),
    .ent_tag   (ent_tag),
    .ent_opa   (ent_opa),
    .ent_opb   (ent_opb),
    .ent_res   (ent_res),
    .ent_addr  (ent_addr)
  );

  irb_tag_stage #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_idx    (lk_idx),
    .lk_tag    (lk_tag),
    .cm_valid  (cm_valid),
    .cm_idx    (cm_idx),
    .ent_valid (ent_valid),
    .ent_tag   (ent_tag),
    .s1_valid  (s1_valid),
    .s1_idx    (s1_idx),
    .s1_taghit (s1_taghit)
  );

  irb_opnd_stage #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_opnd (
    .clk       (clk),
    .rst_n     (rst_n),
    .s1_valid  (s1_valid),
    .s1_idx    (s1_idx),
    .s1_taghit (s1_taghit),
    .opa       (lk_opa),
    .opb       (lk_opb),
    .ent_flags (ent_flags),
    .ent_opa   (ent_opa),
    .ent_opb   (ent_opb),
    .ent_res   (ent_res),
    .ent_addr  (ent_addr),
    .rs_valid  (rs_valid),
    .rs_hit    (rs_hit),
    .rs_mem_ok (rs_mem_ok),
    .rs_result (rs_result),
    .rs_addr   (rs_addr)
  );

endmodule

// File: rtl/irb_chk.sv
module irb_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              rs_valid,
  input logic              rs_hit,
  input logic              rs_mem_ok,
  input logic [DATA_W-1:0] rs_result,
  input logic [ADDR_W-1:0] rs_addr
);

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    !rst_n |=> !rs_valid);

  // R2
  answer_follows_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> ##2 rs_valid);

  // R2
  no_unrequested_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> ##2 !rs_valid);

  // R2
  hit_needs_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> (!rs_hit && !rs_mem_ok));

  // R7
  load_ok_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_mem_ok |-> rs_hit);

  // R11
  miss_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |-> (rs_result == '0 && rs_addr == '0 && !rs_mem_ok));

endmodule

bind reuse_buffer irb_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_irb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_valid  (lk_valid),
  .rs_valid  (rs_valid),
  .rs_hit    (rs_hit),
  .rs_mem_ok (rs_mem_ok),
  .rs_result (rs_result),
  .rs_addr   (rs_addr)
);

// File: tb/reuse_buffer_bench.sv
module reuse_buffer_bench;
  localparam int PC_W = 32, DATA_W = 32, ADDR_W = 32, ENTRIES = 16, ALIGN = 2;
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              lk_valid = 0, cm_valid = 0, cm_single = 0, cm_load = 0, st_valid = 0;
  logic [PC_W-1:0]   lk_pc = '0, cm_pc = '0;
  logic [DATA_W-1:0] lk_opa = '0, lk_opb = '0, cm_opa = '0, cm_opb = '0, cm_result = '0;
  logic [ADDR_W-1:0] cm_addr = '0, st_addr = '0;
  logic              rs_valid, rs_hit, rs_mem_ok;
  logic [DATA_W-1:0] rs_result;
  logic [ADDR_W-1:0] rs_addr;

  reuse_buffer #(.PC_W(PC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                 .ENTRIES(ENTRIES), .ALIGN(ALIGN)) u_reuse_buffer (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_opa(lk_opa), .lk_opb(lk_opb),
    .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_mem_ok(rs_mem_ok),
    .rs_result(rs_result), .rs_addr(rs_addr),
    .cm_valid(cm_valid), .cm_pc(cm_pc), .cm_single(cm_single), .cm_load(cm_load),
    .cm_opa(cm_opa), .cm_opb(cm_opb), .cm_result(cm_result), .cm_addr(cm_addr),
    .st_valid(st_valid), .st_addr(st_addr)
  );

  // Reference table built from the requirements
  bit                m_valid [ENTRIES];
  logic [TAG_W-1:0]  m_tag   [ENTRIES];
  bit                m_single[ENTRIES], m_load[ENTRIES], m_mv[ENTRIES];
  logic [DATA_W-1:0] m_opa[ENTRIES], m_opb[ENTRIES], m_res[ENTRIES];
  logic [ADDR_W-1:0] m_addr[ENTRIES];

  // Pending request (tag step) and the answer expected after the next edge
  bit e1_v, e1_hit; int e1_idx; string e1_req = "R2";
  bit ex_v, ex_hit, ex_ok; logic [DATA_W-1:0] ex_res; logic [ADDR_W-1:0] ex_addr;
  string ex_req = "R1";

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic int f_idx(logic [PC_W-1:0] pc);
    return int'(pc[ALIGN +: IDX_W]);
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(logic [PC_W-1:0] pc);
    return {pc[PC_W-1:ALIGN+IDX_W], pc[ALIGN-1:0]};
  endfunction

  task automatic chk1(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    lk_valid = 0; lk_pc = '0; lk_opa = '0; lk_opb = '0;
    cm_valid = 0; cm_pc = '0; cm_single = 0; cm_load = 0;
    cm_opa = '0; cm_opb = '0; cm_result = '0; cm_addr = '0;
    st_valid = 0; st_addr = '0;
  endtask

  // Inputs are set at a falling edge; predict the next rising edge, then check.
  task automatic step(string req);
    int i;
    ex_v   = e1_v;
    ex_req = e1_req;
    ex_hit = e1_v && e1_hit && (lk_opa == m_opa[e1_idx]) &&
             (m_single[e1_idx] || lk_opb == m_opb[e1_idx]);
    ex_ok   = ex_hit && m_load[e1_idx] && m_mv[e1_idx];
    ex_res  = ex_hit ? m_res[e1_idx]  : '0;
    ex_addr = ex_hit ? m_addr[e1_idx] : '0;
    // tag step, R10: a commit to the same index in the request cycle forces a miss
    e1_v   = lk_valid;
    e1_idx = f_idx(lk_pc);
    e1_hit = lk_valid && m_valid[e1_idx] && (m_tag[e1_idx] == f_tag(lk_pc)) &&
             !(cm_valid && f_idx(cm_pc) == e1_idx);
    e1_req = req;
    // table update: commit first, then store snoop (store wins, R9)
    if (cm_valid) begin
      i = f_idx(cm_pc);
      m_valid[i] = 1; m_tag[i] = f_tag(cm_pc); m_single[i] = cm_single;
      m_load[i] = cm_load; m_mv[i] = cm_load; m_opa[i] = cm_opa; m_opb[i] = cm_opb;
      m_res[i] = cm_result; m_addr[i] = cm_addr;
    end
    if (st_valid)
      for (int j = 0; j < ENTRIES; j++)
        if (m_addr[j] == st_addr) m_mv[j] = 0;
    @(negedge clk);
    chk1(ex_req, "rs_valid",  64'(rs_valid),  64'(ex_v));
    chk1(ex_req, "rs_hit",    64'(rs_hit),    64'(ex_hit));
    chk1(ex_req, "rs_mem_ok", 64'(rs_mem_ok), 64'(ex_ok));
    chk1(ex_req, "rs_result", 64'(rs_result), 64'(ex_res));
    chk1(ex_req, "rs_addr",   64'(rs_addr),   64'(ex_addr));
  endtask

  task automatic lookup(logic [PC_W-1:0] pc, logic [DATA_W-1:0] a, logic [DATA_W-1:0] b,
                        string req);
    clr(); lk_valid = 1; lk_pc = pc; step(req);
    clr(); lk_opa = a; lk_opb = b;   step(req);
    clr();
  endtask

  task automatic commit(logic [PC_W-1:0] pc, bit single, bit load, logic [DATA_W-1:0] a,
                        logic [DATA_W-1:0] b, logic [DATA_W-1:0] r,
                        logic [ADDR_W-1:0] ad, string req);
    clr(); cm_valid = 1; cm_pc = pc; cm_single = single; cm_load = load;
    cm_opa = a; cm_opb = b; cm_result = r; cm_addr = ad;
    step(req); clr();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic logic [PC_W-1:0] pick_pc();
    return PC_W'((($urandom % 2) + 1) << (ALIGN + IDX_W)) | PC_W'(($urandom % 4) << ALIGN);
  endfunction

  localparam logic [PC_W-1:0] P1 = 32'h104, P3 = 32'h204, P2 = 32'h108, P4 = 32'h10C;

  initial begin
    for (int j = 0; j < ENTRIES; j++) begin
      m_valid[j] = 0; m_mv[j] = 0; m_addr[j] = '0; m_tag[j] = '0; m_single[j] = 0;
      m_load[j] = 0; m_opa[j] = '0; m_opb[j] = '0; m_res[j] = '0;
    end
    e1_v = 0; e1_hit = 0; e1_idx = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: outputs idle while reset is held
    chk1("R1", "rs_valid in reset", 64'(rs_valid), 64'd0);
    chk1("R1", "rs_hit in reset", 64'(rs_hit), 64'd0);
    chk1("R1", "rs_result in reset", 64'(rs_result), 64'd0);
    rst_n = 1'b1;
    lookup(P1, 32'd0, 32'd0, "R1");                       // empty table misses
    commit(P1, 0, 1, 32'd5, 32'd6, 32'd77, 32'hA0, "R6"); // load entry
    lookup(P1, 32'd5, 32'd6, "R7");                       // hit, value usable
    lookup(P1, 32'd5, 32'd7, "R3");                       // second operand differs
    lookup(P1, 32'd4, 32'd6, "R11");                      // miss returns zeros
    clr(); st_valid = 1; st_addr = 32'hA0; step("R8"); clr();
    lookup(P1, 32'd5, 32'd6, "R8");                       // hit, value stale
    commit(P2, 1, 0, 32'd9, 32'd1, 32'd55, 32'h0, "R6");  // one-source ALU op
    lookup(P2, 32'd9, 32'd123, "R4");
    lookup(P2, 32'd8, 32'd1, "R4");
    // R9: commit of a load and a matching store in one cycle
    clr(); cm_valid = 1; cm_pc = P4; cm_load = 1; cm_opa = 3; cm_opb = 4;
    cm_result = 32'd99; cm_addr = 32'hB0; st_valid = 1; st_addr = 32'hB0;
    step("R9"); clr();
    lookup(P4, 32'd3, 32'd4, "R9");
    commit(P4, 0, 1, 32'd3, 32'd4, 32'd98, 32'hC0, "R6");
    lookup(P4, 32'd3, 32'd4, "R6");
    // R10: commit to the same index in the request cycle forces a miss
    clr(); lk_valid = 1; lk_pc = P4; cm_valid = 1; cm_pc = P4; cm_load = 1;
    cm_opa = 3; cm_opb = 4; cm_result = 32'd11; cm_addr = 32'hC4; step("R10");
    clr(); lk_opa = 3; lk_opb = 4; step("R10"); clr();
    // R10: a commit in the operand cycle is not seen by that request
    clr(); lk_valid = 1; lk_pc = P4; step("R10");
    clr(); lk_opa = 3; lk_opb = 4; cm_valid = 1; cm_pc = P4; cm_opa = 7; cm_opb = 7;
    cm_result = 32'd12; cm_addr = 32'hC8; step("R10"); clr();
    // R5: a different tag at the same index replaces the slot
    commit(P3, 0, 0, 32'd1, 32'd2, 32'd33, 32'h0, "R5");
    lookup(P1, 32'd5, 32'd6, "R5");
    lookup(P3, 32'd1, 32'd2, "R5");
    // R8: one store clears every entry that shares its address
    commit(P2, 0, 1, 32'd1, 32'd1, 32'd21, 32'hD0, "R8");
    commit(P4, 0, 1, 32'd2, 32'd2, 32'd22, 32'hD0, "R8");
    commit(P1, 0, 1, 32'd5, 32'd6, 32'd23, 32'hE0, "R8");
    clr(); st_valid = 1; st_addr = 32'hD0; step("R8"); clr();
    lookup(P2, 32'd1, 32'd1, "R8");
    lookup(P4, 32'd2, 32'd2, "R8");
    lookup(P1, 32'd5, 32'd6, "R8");
    // Random traffic with heavy collisions, back-to-back requests
    for (int k = 0; k < 4000; k++) begin
      clr();
      lk_valid = (($urandom % 10) < 6);
      lk_pc    = pick_pc();
      if (e1_v && ($urandom % 2) == 1) begin
        lk_opa = m_opa[e1_idx];
        lk_opb = (($urandom % 4) == 0) ? DATA_W'($urandom % 4) : m_opb[e1_idx];
      end else begin
        lk_opa = DATA_W'($urandom % 4);
        lk_opb = DATA_W'($urandom % 4);
      end
      cm_valid  = (($urandom % 10) < 3);
      cm_pc     = pick_pc();
      cm_single = (($urandom % 4) == 0);
      cm_load   = (($urandom % 2) == 1);
      cm_opa    = DATA_W'($urandom % 4);
      cm_opb    = DATA_W'($urandom % 4);
      cm_result = DATA_W'($urandom);
      cm_addr   = ADDR_W'(($urandom % 4) << 4);
      st_valid  = (($urandom % 5) == 0);
      st_addr   = ADDR_W'(($urandom % 4) << 4);
      step("R3");
    end
    clr(); step("R2"); step("R2");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule